// File: doc/BRIEF.md
# Multi-Cycle Datapath Instruction Sequencer

This block runs a short program of datapath instructions held in a small instruction buffer against a four-entry register file of 64-bit words. Four operations exist: exclusive-or, left rotate, logical left shift and register move. Every instruction occupies a fixed number of clock cycles, and the block reports how long each one took and how long the whole program took.

The program and the initial register contents are written through two load ports while the block is idle. A start strobe then launches the program with a given length and a mode bit. In baseline mode, each instruction walks through a decode cycle, a delay-computation phase and a register-allocation phase. In aligned mode, a per-opcode delay table is loaded once at reset. The sequencer reads each instruction's allocation hold from that table and skips the delay-computation phase entirely, so the same program finishes in fewer cycles. When the last instruction retires, the block raises a done flag. It also shows the final result word, the total cycle count and the operational and synchronisation cycle counts of the last instruction.

Top module: `op_seq_engine`

## Requirements
- R1: An instruction word is 13 bits wide. Bits [12:10] hold the header, [9:8] the destination register, [7:6] the source register and [5:0] the amount. The header codes are 1 exclusive-or, 2 rotate, 3 shift and 4 move.
- R2: Exclusive-or writes destination XOR source into the destination register. Move copies the source register into the destination register.
- R3: Rotate writes the source rotated left by the amount. Shift writes the source shifted left by the amount with zero fill. An amount of 0 copies the source unchanged.
- R4: In baseline mode, exclusive-or and move take 6 cycles each, with operational count 3 and synchronisation count 3. Rotate and shift take 4 cycles each, with operational count 2 and synchronisation count 2.
- R5: In aligned mode, the delay table holds 6 for move and exclusive-or and 4 for rotate and shift. No delay-computation cycles run. Exclusive-or and move take 4 cycles (operational 1, synchronisation 3). Rotate and shift take 3 cycles (operational 1, synchronisation 2).
- R6: Header codes 0, 5, 6 and 7 are one-cycle no-ops, with operational count 1 and synchronisation count 0. They change no register and do not change the final data output.
- R7: The total cycle counter clears on start and counts every execution cycle. When done is raised, it equals the sum of the instruction costs, and it holds that value while done stays high.
- R8: Done rises exactly as many cycles after the start edge as the program's total cost, and stays high until the next start. A program of length 0 raises done after the start edge with a total of 0.
- R9: The final data output shows the value written by the most recent executing instruction. After done, the operational and synchronisation outputs show the last instruction's counts.
- R10: Reset clears the register file, the instruction buffer, the final data, all counters and done.
- R11: Register contents persist from one program to the next, so a later program works on the results of an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_wr_en_i | input | 1 | Register preload write enable; taken only while the block is not running |
| rf_wr_idx_i | input | 2 | Register preload index |
| rf_wr_data_i | input | 64 | Register preload data |
| ib_wr_en_i | input | 1 | Instruction buffer write enable |
| ib_wr_addr_i | input | 3 | Instruction buffer slot |
| ib_wr_insn_i | input | 13 | Instruction word to store |
| start_i | input | 1 | Starts the program; ignored while running |
| prog_len_i | input | 4 | Number of instructions to run from slot 0, limited to the buffer depth |
| aligned_i | input | 1 | 1 selects aligned mode, 0 baseline; sampled at start |
| final_data_o | output | 64 | Result of the last executing instruction |
| done_o | output | 1 | Program complete |
| total_cycles_o | output | 16 | Cycles spent executing the current or last program |
| op_cycles_o | output | 4 | Decode plus delay-computation cycles of the latest instruction |
| sync_cycles_o | output | 4 | Register-allocation cycles of the latest instruction |

## Verification
On every cycle, the assertions check the following:
- the total counter advances by one each execution cycle and stays frozen while done is held;
- no instruction's phase count exceeds 6 cycles in baseline mode or 4 in aligned mode;
- a no-op retires in its first cycle;
- an aligned instruction always reports a single operational cycle.

The actual data results, the exact per-opcode cycle totals, the clearing effect of reset on the register file and instruction buffer, and the persistence of register state across programs can only be shown by the bench's scenarios. To show them, the bench compares a baseline and an aligned run of the same program.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  localparam int HDR_W = 3;
  localparam int PH_W  = 4;

  localparam logic [HDR_W-1:0] HDR_XOR = 3'd1;
  localparam logic [HDR_W-1:0] HDR_ROL = 3'd2;
  localparam logic [HDR_W-1:0] HDR_SHL = 3'd3;
  localparam logic [HDR_W-1:0] HDR_MOV = 3'd4;

  function automatic logic hdr_exec(input logic [HDR_W-1:0] h);
    return (h == HDR_XOR) || (h == HDR_ROL) || (h == HDR_SHL) || (h == HDR_MOV);
  endfunction

  // baseline delay-computation phase length
  function automatic logic [PH_W-1:0] comp_len(input logic [HDR_W-1:0] h);
    case (h)
      HDR_XOR, HDR_MOV: return PH_W'(2);
      HDR_ROL, HDR_SHL: return PH_W'(1);
      default:          return PH_W'(0);
    endcase
  endfunction

  // baseline register-allocation phase length
  function automatic logic [PH_W-1:0] alloc_len(input logic [HDR_W-1:0] h);
    case (h)
      HDR_XOR, HDR_MOV: return PH_W'(3);
      HDR_ROL, HDR_SHL: return PH_W'(2);
      default:          return PH_W'(0);
    endcase
  endfunction

  // contents of the precomputed delay reference table
  function automatic logic [PH_W-1:0] table_len(input logic [HDR_W-1:0] h);
    case (h)
      HDR_XOR, HDR_MOV: return PH_W'(6);
      HDR_ROL, HDR_SHL: return PH_W'(4);
      default:          return PH_W'(1);
    endcase
  endfunction

  // aligned allocation hold: table value less the skipped compute cycles and decode
  function automatic logic [PH_W-1:0] aligned_alloc(input logic [PH_W-1:0] tbl,
                                                     input logic [HDR_W-1:0] h);
    int d;
    d = int'(tbl) - int'(comp_len(h)) - 1;
    return (d < 1) ? PH_W'(1) : PH_W'(d);
  endfunction
endpackage

// File: rtl/opseq_ibuf.sv
module opseq_ibuf #(
  parameter int DEPTH  = 8,
  parameter int INSN_W = 13,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [INSN_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  output logic [INSN_W-1:0] rd
);
  logic [DEPTH-1:0][INSN_W-1:0] slots;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [INSN_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q <= '0;
      else if (we && wa == AW'(g))      q <= wd;
    end
    assign slots[g] = q;
  end

  assign rd = slots[ra];
endmodule

// File: rtl/opseq_rf.sv
module opseq_rf #(
  parameter int DATA_W = 64,
  parameter int NREG   = 4,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [IDX_W-1:0]  ra0,
  input  logic [IDX_W-1:0]  ra1,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1
);
  logic [NREG-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= '0;
      else if (we && wa == IDX_W'(g))    q <= wd;
    end
    assign regs[g] = q;
  end

  assign rd0 = regs[ra0];
  assign rd1 = regs[ra1];
endmodule

// File: rtl/opseq_alu.sv
module opseq_alu import opseq_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [HDR_W-1:0]  hdr,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] res
);
  function automatic logic [DATA_W-1:0] rot_left(input logic [DATA_W-1:0] x,
                                                 input logic [AMT_W-1:0]  a);
    logic [2*DATA_W-1:0] dbl;
    dbl = {x, x} << a;
    return dbl[2*DATA_W-1 -: DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] shf_left(input logic [DATA_W-1:0] x,
                                                 input logic [AMT_W-1:0]  a);
    return x << a;
  endfunction

  always_comb begin
    case (hdr)
      HDR_XOR: res = dst_val ^ src_val;
      HDR_ROL: res = rot_left(src_val, amt);
      HDR_SHL: res = shf_left(src_val, amt);
      HDR_MOV: res = src_val;
      default: res = dst_val;
    endcase
  end
endmodule

// File: rtl/opseq_timing.sv
module opseq_timing import opseq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HDR_W-1:0] hdr,
  input  logic             aligned,
  output logic [PH_W-1:0]  dec_c,
  output logic [PH_W-1:0]  comp_c,
  output logic [PH_W-1:0]  alloc_c,
  output logic [PH_W-1:0]  cost
);
  localparam int NENT = 1 << HDR_W;

  logic [NENT-1:0][PH_W-1:0] tbl;

  // reference table, filled once at reset and held afterwards
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic [PH_W-1:0] v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v <= table_len(HDR_W'(g));
      else        v <= v;
    end
    assign tbl[g] = v;
  end

  always_comb begin
    dec_c = PH_W'(1);
    if (!hdr_exec(hdr)) begin
      comp_c  = '0;
      alloc_c = '0;
    end else if (aligned) begin
      comp_c  = '0;
      alloc_c = aligned_alloc(tbl[hdr], hdr);
    end else begin
      comp_c  = comp_len(hdr);
      alloc_c = alloc_len(hdr);
    end
    cost = dec_c + comp_c + alloc_c;
  end
endmodule

// File: rtl/op_seq_engine.sv
module op_seq_engine import opseq_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int NREG   = 4,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       rf_wr_en_i,
  input  logic [$clog2(NREG)-1:0]                    rf_wr_idx_i,
  input  logic [DATA_W-1:0]                          rf_wr_data_i,
  input  logic                                       ib_wr_en_i,
  input  logic [$clog2(DEPTH)-1:0]                   ib_wr_addr_i,
  input  logic [HDR_W+2*$clog2(NREG)+$clog2(DATA_W)-1:0] ib_wr_insn_i,
  input  logic                                       start_i,
  input  logic [$clog2(DEPTH+1)-1:0]                 prog_len_i,
  input  logic                                       aligned_i,
  output logic [DATA_W-1:0]                          final_data_o,
  output logic                                       done_o,
  output logic [CNT_W-1:0]                           total_cycles_o,
  output logic [PH_W-1:0]                            op_cycles_o,
  output logic [PH_W-1:0]                            sync_cycles_o
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int AMT_W  = $clog2(DATA_W);
  localparam int INSN_W = HDR_W + 2*IDX_W + AMT_W;
  localparam int PC_W   = $clog2(DEPTH);
  localparam int LEN_W  = $clog2(DEPTH+1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;

  st_e               st;
  logic              mode_q;
  logic [PC_W-1:0]   pc;
  logic [LEN_W-1:0]  len_q;
  logic [PH_W-1:0]   phase;
  logic [DATA_W-1:0] final_q;
  logic [CNT_W-1:0]  total_q;
  logic [PH_W-1:0]   op_q, sync_q;

  logic [INSN_W-1:0] insn;
  logic [HDR_W-1:0]  hdr;
  logic [IDX_W-1:0]  dst, src;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] dst_val, src_val, alu_res;
  logic [PH_W-1:0]   dec_c, comp_c, alloc_c, cost;

  // named internal events
  logic busy, first_cyc, retire, last_insn, cur_noop, exec_wr, start_ok;
  logic [LEN_W-1:0] len_in;

  assign busy      = (st == ST_RUN);
  assign start_ok  = start_i && !busy;
  assign hdr       = insn[INSN_W-1 -: HDR_W];
  assign dst       = insn[AMT_W+2*IDX_W-1 -: IDX_W];
  assign src       = insn[AMT_W+IDX_W-1 -: IDX_W];
  assign amt       = insn[AMT_W-1:0];
  assign cur_noop  = !hdr_exec(hdr);
  assign first_cyc = busy && (phase == '0);
  assign retire    = busy && (phase == cost - PH_W'(1));
  assign last_insn = (LEN_W'(pc) + LEN_W'(1)) == len_q;
  assign exec_wr   = retire && !cur_noop;
  assign len_in    = (prog_len_i > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : prog_len_i;

  logic              rf_we;
  logic [IDX_W-1:0]  rf_wa;
  logic [DATA_W-1:0] rf_wd;

  always_comb begin
    if (busy) begin
      rf_we = exec_wr;
      rf_wa = dst;
      rf_wd = alu_res;
    end else begin
      rf_we = rf_wr_en_i;
      rf_wa = rf_wr_idx_i;
      rf_wd = rf_wr_data_i;
    end
  end

  opseq_ibuf #(.DEPTH(DEPTH), .INSN_W(INSN_W), .AW(PC_W)) u_ibuf (
    .clk(clk), .rst_n(rst_n), .we(ib_wr_en_i), .wa(ib_wr_addr_i),
    .wd(ib_wr_insn_i), .ra(pc), .rd(insn)
  );

  opseq_rf #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra0(dst), .ra1(src), .rd0(dst_val), .rd1(src_val)
  );

  opseq_alu #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_alu (
    .hdr(hdr), .dst_val(dst_val), .src_val(src_val), .amt(amt), .res(alu_res)
  );

  opseq_timing u_timing (
    .clk(clk), .rst_n(rst_n), .hdr(hdr), .aligned(mode_q),
    .dec_c(dec_c), .comp_c(comp_c), .alloc_c(alloc_c), .cost(cost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      mode_q  <= 1'b0;
      pc      <= '0;
      len_q   <= '0;
      phase   <= '0;
      final_q <= '0;
      total_q <= '0;
      op_q    <= '0;
      sync_q  <= '0;
    end else if (start_ok) begin
      mode_q  <= aligned_i;
      len_q   <= len_in;
      pc      <= '0;
      phase   <= '0;
      total_q <= '0;
      st      <= (len_in == '0) ? ST_DONE : ST_RUN;
    end else if (busy) begin
      total_q <= total_q + CNT_W'(1);
      if (first_cyc) begin
        op_q   <= dec_c + comp_c;
        sync_q <= alloc_c;
      end
      if (retire) begin
        phase <= '0;
        if (exec_wr) final_q <= alu_res;
        if (last_insn) st <= ST_DONE;
        else           pc <= pc + PC_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  assign final_data_o   = final_q;
  assign done_o         = (st == ST_DONE);
  assign total_cycles_o = total_q;
  assign op_cycles_o    = op_q;
  assign sync_cycles_o  = sync_q;
endmodule

// File: rtl/op_seq_engine_chk.sv
module op_seq_engine_chk #(
  parameter int CNT_W = 16,
  parameter int PH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             first_cyc,
  input logic             retire,
  input logic             cur_noop,
  input logic             mode_q,
  input logic [PH_W-1:0]  phase,
  input logic             start_i,
  input logic             done_o,
  input logic [CNT_W-1:0] total_cycles_o,
  input logic [PH_W-1:0]  op_cycles_o
);
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (total_cycles_o == $past(total_cycles_o) + 1'b1)); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(total_cycles_o))); // R8

  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(retire) || $past(start_i))); // R8

  AST_BASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase < 6)); // R4

  AST_ALIGNED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |-> (phase < 4)); // R5

  AST_ALIGNED_OP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q && first_cyc) |=> (op_cycles_o == 1)); // R5

  AST_NOOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_noop) |-> retire); // R6
endmodule

bind op_seq_engine op_seq_engine_chk #(.CNT_W(CNT_W), .PH_W(opseq_pkg::PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .first_cyc(first_cyc), .retire(retire),
  .cur_noop(cur_noop), .mode_q(mode_q), .phase(phase), .start_i(start_i),
  .done_o(done_o), .total_cycles_o(total_cycles_o), .op_cycles_o(op_cycles_o)
);

// File: tb/op_seq_engine_tb.sv
module op_seq_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_wr_en_i = 1'b0;
  logic [1:0]  rf_wr_idx_i = '0;
  logic [63:0] rf_wr_data_i = '0;
  logic        ib_wr_en_i = 1'b0;
  logic [2:0]  ib_wr_addr_i = '0;
  logic [12:0] ib_wr_insn_i = '0;
  logic        start_i = 1'b0;
  logic [3:0]  prog_len_i = '0;
  logic        aligned_i = 1'b0;
  logic [63:0] final_data_o;
  logic        done_o;
  logic [15:0] total_cycles_o;
  logic [3:0]  op_cycles_o;
  logic [3:0]  sync_cycles_o;

  op_seq_engine u_dut (
    .clk(clk), .rst_n(rst_n), .rf_wr_en_i(rf_wr_en_i), .rf_wr_idx_i(rf_wr_idx_i),
    .rf_wr_data_i(rf_wr_data_i), .ib_wr_en_i(ib_wr_en_i), .ib_wr_addr_i(ib_wr_addr_i),
    .ib_wr_insn_i(ib_wr_insn_i), .start_i(start_i), .prog_len_i(prog_len_i),
    .aligned_i(aligned_i), .final_data_o(final_data_o), .done_o(done_o),
    .total_cycles_o(total_cycles_o), .op_cycles_o(op_cycles_o), .sync_cycles_o(sync_cycles_o)
  );

  always #10 clk = ~clk; // 50 MHz

  int total_n = 0;
  int bad_n   = 0;
  int wd_cnt  = 0;

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      bad_n++;
      total_n++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end

  // R1 encoding: [12:10] header, [9:8] dst, [7:6] src, [5:0] amount
  function automatic logic [12:0] enc(input int h, input int d, input int s, input int a);
    return {3'(h), 2'(d), 2'(s), 6'(a)};
  endfunction

  localparam logic [12:0] Z = 13'd0;
  localparam int NV = 8;
  // {aligned, len, i0, i1, i2, i3}
  localparam logic [56:0] VEC [NV] = '{
    {1'b0, 4'd1, enc(1,0,1,0), Z, Z, Z},
    {1'b1, 4'd1, enc(1,0,1,0), Z, Z, Z},
    {1'b0, 4'd2, enc(2,1,2,1), enc(3,3,2,63), Z, Z},
    {1'b1, 4'd2, enc(2,0,3,32), enc(4,2,0,0), Z, Z},
    {1'b0, 4'd4, enc(5,0,0,0), enc(4,1,3,0), enc(1,1,0,0), enc(7,2,2,9)},
    {1'b1, 4'd4, enc(3,0,1,0), enc(2,2,2,63), enc(0,1,1,1), enc(4,3,2,0)},
    {1'b0, 4'd4, enc(1,2,3,0), enc(2,3,1,5), enc(3,1,0,4), enc(4,0,2,0)},
    {1'b1, 4'd4, enc(1,2,3,0), enc(2,3,1,5), enc(3,1,0,4), enc(4,0,2,0)}
  };

  // bench-side model
  logic [63:0] m_rf [4];
  logic [63:0] m_final;
  int          m_op, m_sync;
  logic [12:0] prog [4];

  function automatic logic [63:0] m_rol(input logic [63:0] x, input int a);
    logic [63:0] y;
    for (int k = 0; k < 64; k++) y[(k + a) % 64] = x[k];
    return y;
  endfunction

  function automatic logic [63:0] m_shl(input logic [63:0] x, input int a);
    logic [63:0] y = '0;
    for (int k = 0; k < 64; k++) if (k + a < 64) y[k + a] = x[k];
    return y;
  endfunction

  task automatic model_run(input int len, input bit al, output int tot);
    tot = 0;
    for (int i = 0; i < len; i++) begin
      int h, d, s, a;
      h = int'(prog[i][12:10]); d = int'(prog[i][9:8]);
      s = int'(prog[i][7:6]);   a = int'(prog[i][5:0]);
      case (h)
        1: begin m_rf[d] = m_rf[d] ^ m_rf[s]; m_final = m_rf[d];
                 tot += al ? 4 : 6; m_op = al ? 1 : 3; m_sync = 3; end
        4: begin m_rf[d] = m_rf[s]; m_final = m_rf[d];
                 tot += al ? 4 : 6; m_op = al ? 1 : 3; m_sync = 3; end
        2: begin m_rf[d] = m_rol(m_rf[s], a); m_final = m_rf[d];
                 tot += al ? 3 : 4; m_op = al ? 1 : 2; m_sync = 2; end
        3: begin m_rf[d] = m_shl(m_rf[s], a); m_final = m_rf[d];
                 tot += al ? 3 : 4; m_op = al ? 1 : 2; m_sync = 2; end
        default: begin tot += 1; m_op = 1; m_sync = 0; end
      endcase
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int r = 0; r < 4; r++) m_rf[r] = '0;
    m_final = '0; m_op = 0; m_sync = 0;
  endtask

  task automatic load_reg(input int idx, input logic [63:0] v);
    @(negedge clk); rf_wr_en_i = 1'b1; rf_wr_idx_i = 2'(idx); rf_wr_data_i = v;
    @(negedge clk); rf_wr_en_i = 1'b0;
    m_rf[idx] = v;
  endtask

  task automatic load_prog();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ib_wr_en_i = 1'b1; ib_wr_addr_i = 3'(i); ib_wr_insn_i = prog[i];
    end
    @(negedge clk); ib_wr_en_i = 1'b0;
  endtask

  task automatic run_prog(input int len, input bit al, output int lat);
    @(negedge clk); start_i = 1'b1; prog_len_i = 4'(len); aligned_i = al;
    @(negedge clk); start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk); lat++;
    end
  endtask

  initial begin
    int lat, tot, keep;
    string mreq;
    do_reset();
    // R10 reset state
    chk("R10 done after reset", 64'(done_o), 64'd0);
    chk("R10 total after reset", 64'(total_cycles_o), 64'd0);
    chk("R10 final after reset", final_data_o, 64'd0);
    chk("R10 op after reset", 64'(op_cycles_o), 64'd0);
    chk("R10 sync after reset", 64'(sync_cycles_o), 64'd0);

    load_reg(0, 64'h0123_4567_89AB_CDEF);
    load_reg(1, 64'hF0F0_F0F0_0F0F_0F0F);
    load_reg(2, 64'h8000_0000_0000_0001);
    load_reg(3, 64'h0000_0000_FFFF_FFFF);

    for (int v = 0; v < NV; v++) begin
      bit al;
      int len;
      al  = VEC[v][56];
      len = int'(VEC[v][55:52]);
      prog[0] = VEC[v][51:39]; prog[1] = VEC[v][38:26];
      prog[2] = VEC[v][25:13]; prog[3] = VEC[v][12:0];
      load_prog();
      model_run(len, al, tot);
      run_prog(len, al, lat);
      mreq = al ? "R5" : "R4";
      chk({"R8 latency ", mreq}, 64'(lat), 64'(tot));
      chk({"R7 total ", mreq}, 64'(total_cycles_o), 64'(tot));
      chk("R9 R2 R3 R11 final", final_data_o, m_final);
      chk({"R9 op ", mreq}, 64'(op_cycles_o), 64'(m_op));
      chk({"R9 sync ", mreq}, 64'(sync_cycles_o), 64'(m_sync));
    end

    // R6: lone no-op keeps final and registers
    prog[0] = enc(6,0,1,7); prog[1] = enc(4,0,0,0); prog[2] = Z; prog[3] = Z;
    load_prog();
    keep = 0;
    model_run(1, 1'b0, tot);
    run_prog(1, 1'b0, lat);
    chk("R6 noop total", 64'(total_cycles_o), 64'd1);
    chk("R6 noop final unchanged", final_data_o, m_final);
    chk("R6 noop op", 64'(op_cycles_o), 64'd1);
    chk("R6 noop sync", 64'(sync_cycles_o), 64'd0);
    prog[0] = enc(4,0,0,0);
    load_prog();
    model_run(1, 1'b0, tot);
    run_prog(1, 1'b0, lat);
    chk("R6 register untouched by noop", final_data_o, m_rf[0]);

    // R8 zero-length program
    run_prog(0, 1'b0, lat);
    chk("R8 zero length latency", 64'(lat), 64'd0);
    chk("R8 zero length done", 64'(done_o), 64'd1);
    chk("R7 zero length total", 64'(total_cycles_o), 64'd0);

    // R7/R8 done held with a stable total
    prog[0] = enc(2,1,0,3); prog[1] = Z; prog[2] = Z; prog[3] = Z;
    load_prog();
    model_run(1, 1'b1, tot);
    run_prog(1, 1'b1, lat);
    for (int w = 0; w < 5; w++) @(negedge clk);
    chk("R8 done held", 64'(done_o), 64'd1);
    chk("R7 total held", 64'(total_cycles_o), 64'(tot));
    keep = tot;

    // R10: reset clears buffer and registers
    load_reg(1, 64'hDEAD_BEEF_0000_1111);
    do_reset();
    run_prog(1, 1'b0, lat);
    chk("R10 cleared buffer runs as noop", 64'(total_cycles_o), 64'd1);
    chk("R10 final after cleared run", final_data_o, 64'd0);
    prog[0] = enc(4,0,1,0); prog[1] = Z; prog[2] = Z; prog[3] = Z;
    load_prog();
    model_run(1, 1'b0, tot);
    run_prog(1, 1'b0, lat);
    chk("R10 register cleared", final_data_o, 64'd0);
    chk("R4 move after reset total", 64'(total_cycles_o), 64'd6);
    if (keep < 0) $display("unreachable");

    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule